// File: doc/BRIEF.md
# Masked S-Box Table with Background Re-Randomization

This block serves byte substitutions for an AES round from a masked copy of the S-box, so that the table values that pass through the datapath never appear unmasked. One memory of twice the table depth holds two masked copies; the upper address bit selects which copy is meant. One copy (the active context) answers lookups. The other (the passive context) is rewritten in the background under a freshly drawn pair of masks. Once every entry of the passive copy holds its new value, the two copies swap roles on a single clock edge.

A caller reads the current input mask `cur_min` and output mask `cur_mout`, presents `x XOR cur_min` on the lookup port, and one cycle later receives `S(x) XOR m_out`. The mask that applies to that result is reported alongside it. Random bytes arrive through a valid/ready handshake. The first byte accepted for a refill becomes the new input mask and the second becomes the new output mask. If no randomness is offered, the engine waits and lookups carry on unchanged. After reset, context 0 is filled first and becomes active. Only then is `ready` raised.

Top module: `msbox_table`

## Requirements
- R1: While reset is applied and in the first cycle after it, `ready`=0, `busy`=1, `rnd_ready`=1, `swap_pulse`=0 and `lk_dout_valid`=0.
- R2: The first refill after reset writes context 0. `ready` stays 0 until the swap that ends this refill, rises on that swap edge, and `active_ctx`=0 from then on until the next swap.
- R3: A lookup with `lk_valid`=1 and `lk_addr` = x XOR `cur_min` returns `lk_dout` = S(x) XOR `cur_mout` one cycle later, where S is the AES S-box (S(0x00)=0x63, S(0x53)=0xED). `lk_dout_mout` carries the output mask that applies to that result.
- R4: For each refill, the first accepted random byte (`rnd_valid`=1 and `rnd_ready`=1 at a clock edge) becomes the input mask of the refilled context and the second becomes its output mask. Both appear on `cur_min`/`cur_mout` from the swap edge on.
- R5: After the second byte is accepted, the refill writes one entry per cycle for 256 cycles. `swap_pulse` is then high for exactly one cycle, the 257th cycle after the acceptance edge, and `active_ctx` toggles at the end of that cycle.
- R6: Once `ready`=1, every lookup yields `lk_dout_valid`=1 in the next cycle with a correct result, including every cycle of a refill. Lookups never stall.
- R7: A lookup issued in the cycle where `swap_pulse`=1 uses the old context and its old output mask, in both `lk_dout` and `lk_dout_mout`.
- R8: While no random byte is offered, `busy` and `rnd_ready` stay 1, no swap occurs, and `cur_min`, `cur_mout` and the lookup results stay unchanged.
- R9: `swap_pulse`=1 only while `busy`=0. `active_ctx` changes only on the edge that ends a `swap_pulse` cycle, and always to the other context.
- R10: Background writes only ever target the passive context: the context bit of the write address differs from `active_ctx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | W | Masked input byte (x XOR cur_min) |
| lk_dout | output | W | Masked substitution result, one cycle after the request |
| lk_dout_mout | output | W | Output mask applying to lk_dout |
| lk_dout_valid | output | 1 | lk_dout holds a result from a lookup made while ready |
| cur_min | output | W | Input mask of the active context |
| cur_mout | output | W | Output mask of the active context |
| rnd_valid | input | 1 | Random byte offered |
| rnd_data | input | W | Random byte |
| rnd_ready | output | 1 | Engine is waiting for a mask byte |
| busy | output | 1 | Refill in progress (waiting for randomness or writing) |
| swap_pulse | output | 1 | Contexts swap at the end of this cycle |
| ready | output | 1 | A fully written context is active |
| active_ctx | output | 1 | Context currently answering lookups (memory address MSB) |

## Verification
The bench builds the block with its default width W=8, so each context holds the full 256-entry AES table and every entry can be swept and compared against an S-box that the bench derives from log and antilog tables. At this width a refill lasts only 259 cycles. That keeps the first fill, a live refill with lookups issued in every cycle across the swap edge, an all-zero mask pair and long stretches without randomness all within a short run. It also places the exact swap cycle and the old-versus-new mask boundary where they can be checked.

// File: rtl/msbox_pkg.sv
// Package: shared state type and elaboration-time S-box arithmetic.
// Assumes byte-wide field elements over the AES polynomial 0x11B.
package msbox_pkg;

    typedef enum logic [1:0] {
        ST_MIN  = 2'd0,
        ST_MOUT = 2'd1,
        ST_FILL = 2'd2,
        ST_SWAP = 2'd3
    } fill_st_t;

    // Multiply two field elements by shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
        end
        return acc;
    endfunction

    // Field inverse as a^254 (maps zero to zero).
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] res;
        logic [7:0] base;
        logic [7:0] ex;
        res  = 8'h01;
        base = a;
        ex   = 8'hFE;
        for (int i = 0; i < 8; i++) begin
            if (ex[i]) res = gf_mul(res, base);
            base = gf_mul(base, base);
        end
        return res;
    endfunction

    // Unmasked AES substitution: inverse followed by the affine map.
    function automatic logic [7:0] sbox_f(input logic [7:0] x);
        logic [7:0] b;
        b = gf_inv(x);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

endpackage

// File: rtl/msbox_rom.sv
// Unmasked S-box constant table, built at elaboration.
// Assumes W = 8; the read is combinational.
module msbox_rom #(
    parameter int W = 8
) (
    input  logic [W-1:0] addr,
    output logic [W-1:0] data
);
    localparam int DEPTH = 1 << W;

    logic [7:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [7:0] VAL = msbox_pkg::sbox_f(8'(i));
        assign tbl[i] = VAL;
    end

    // Select the entry for the refill counter.
    always_comb data = tbl[addr];

endmodule

// File: rtl/msbox_dpram.sv
// Memory with two ports: A reads synchronously, B writes.
// Assumes both ports never need to read and write the same word in one
// cycle (the controller keeps B on the passive half).
module msbox_dpram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic [AW-1:0] a_addr,
    output logic [DW-1:0] a_q,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_d
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    // Port A: registered read for lookups.
    always_ff @(posedge clk) begin
        if (a_en) a_q <= mem[a_addr];
    end

    // Port B: background write of the passive context.
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_d;
    end

endmodule

// File: rtl/msbox_refill_ctrl.sv
// Refill engine: collects two mask bytes, rewrites the passive context
// one entry per cycle, then swaps contexts. Holds both mask pairs.
// Assumes the caller consumes cur_min/cur_mout as those of active_ctx.
module msbox_refill_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rnd_valid,
    input  logic [W-1:0] rnd_data,
    output logic         rnd_ready,
    output logic         busy,
    output logic         swap_pulse,
    output logic         ready,
    output logic         active_ctx,
    output logic [W-1:0] cur_min,
    output logic [W-1:0] cur_mout,
    output logic [W-1:0] rom_addr,
    input  logic [W-1:0] rom_data,
    output logic         wr_en,
    output logic [W:0]   wr_addr,
    output logic [W-1:0] wr_data
);
    import msbox_pkg::*;

    localparam int           DEPTH = 1 << W;
    localparam logic [W-1:0] LAST  = W'(DEPTH - 1);

    fill_st_t     state;
    logic [W-1:0] ctr;
    logic         act_q;
    logic         rdy_q;
    logic [W-1:0] min_q  [2];
    logic [W-1:0] mout_q [2];
    logic         passive;
    logic         accept;

    assign passive = ~act_q;
    assign accept  = rnd_valid && rnd_ready;

    // Sequence the refill: mask in, mask out, fill, swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_MIN;
            ctr   <= '0;
        end else begin
            case (state)
                ST_MIN:  if (accept) state <= ST_MOUT;
                ST_MOUT: if (accept) begin
                    state <= ST_FILL;
                    ctr   <= '0;
                end
                ST_FILL: begin
                    ctr <= ctr + 1'b1;
                    if (ctr == LAST) state <= ST_SWAP;
                end
                default: state <= ST_MIN;
            endcase
        end
    end

    // Capture fresh masks into the passive context's pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q[0]  <= '0;
            min_q[1]  <= '0;
            mout_q[0] <= '0;
            mout_q[1] <= '0;
        end else if (accept) begin
            if (state == ST_MIN)  min_q[passive]  <= rnd_data;
            if (state == ST_MOUT) mout_q[passive] <= rnd_data;
        end
    end

    // Flip the active context and mark the table usable on a swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b1;
            rdy_q <= 1'b0;
        end else if (state == ST_SWAP) begin
            act_q <= ~act_q;
            rdy_q <= 1'b1;
        end
    end

    // Status, mask reporting and the masked write toward the passive half.
    always_comb begin
        rnd_ready  = (state == ST_MIN) || (state == ST_MOUT);
        busy       = (state != ST_SWAP);
        swap_pulse = (state == ST_SWAP);
        ready      = rdy_q;
        active_ctx = act_q;
        cur_min    = min_q[act_q];
        cur_mout   = mout_q[act_q];
        rom_addr   = ctr;
        wr_en      = (state == ST_FILL);
        wr_addr    = {passive, ctr ^ min_q[passive]};
        wr_data    = rom_data ^ mout_q[passive];
    end

endmodule

// File: rtl/msbox_table.sv
// Top: masked S-box lookup with two contexts in one memory, re-randomized
// in the background. Lookups read the active half through port A while the
// refill engine writes the passive half through port B.
// Assumes W = 8 (AES byte substitution).
module msbox_table #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lk_valid,
    input  logic [W-1:0] lk_addr,
    output logic [W-1:0] lk_dout,
    output logic [W-1:0] lk_dout_mout,
    output logic         lk_dout_valid,
    output logic [W-1:0] cur_min,
    output logic [W-1:0] cur_mout,
    input  logic         rnd_valid,
    input  logic [W-1:0] rnd_data,
    output logic         rnd_ready,
    output logic         busy,
    output logic         swap_pulse,
    output logic         ready,
    output logic         active_ctx
);
    localparam int MAW = W + 1;

    logic [W-1:0] rom_addr;
    logic [W-1:0] rom_data;
    logic         wr_en;
    logic [W:0]   wr_addr;
    logic [W-1:0] wr_data;
    logic [W-1:0] mout_q;
    logic         vld_q;

    msbox_refill_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rnd_valid  (rnd_valid),
        .rnd_data   (rnd_data),
        .rnd_ready  (rnd_ready),
        .busy       (busy),
        .swap_pulse (swap_pulse),
        .ready      (ready),
        .active_ctx (active_ctx),
        .cur_min    (cur_min),
        .cur_mout   (cur_mout),
        .rom_addr   (rom_addr),
        .rom_data   (rom_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    msbox_rom #(.W(W)) u_rom (
        .addr (rom_addr),
        .data (rom_data)
    );

    msbox_dpram #(.AW(MAW), .DW(W)) u_mem (
        .clk    (clk),
        .a_en   (lk_valid),
        .a_addr ({active_ctx, lk_addr}),
        .a_q    (lk_dout),
        .b_we   (wr_en),
        .b_addr (wr_addr),
        .b_d    (wr_data)
    );

    // Carry the output mask and validity of each lookup beside its data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mout_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= lk_valid && ready;
            if (lk_valid) mout_q <= cur_mout;
        end
    end

    assign lk_dout_mout  = mout_q;
    assign lk_dout_valid = vld_q;

endmodule

// File: rtl/msbox_table_chk.sv
// Checker for msbox_table: context-swap and write-target properties.
module msbox_table_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         rnd_ready,
    input logic         swap_pulse,
    input logic         ready,
    input logic         active_ctx,
    input logic         lk_dout_valid,
    input logic [W-1:0] cur_min,
    input logic [W-1:0] cur_mout,
    input logic         wr_en,
    input logic [W:0]   wr_addr
);
    // R10
    passive_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[W] != active_ctx));

    // R9
    swap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> !busy);

    // R9
    swap_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |=> (active_ctx != $past(active_ctx)));

    // R9
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_pulse |=> $stable(active_ctx));

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_pulse |=> ($stable(cur_min) && $stable(cur_mout)));

    // R2
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R6
    valid_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_dout_valid |-> ready);

    // R8
    rnd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_ready |-> busy);

endmodule

bind msbox_table msbox_table_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .rnd_ready     (rnd_ready),
    .swap_pulse    (swap_pulse),
    .ready         (ready),
    .active_ctx    (active_ctx),
    .lk_dout_valid (lk_dout_valid),
    .cur_min       (cur_min),
    .cur_mout      (cur_mout),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr)
);

// File: tb/sim_msbox_table.sv
// Directed bench for msbox_table; drives and samples on the falling edge.
module sim_msbox_table;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lk_valid = 1'b0;
    logic [W-1:0] lk_addr = '0;
    logic [W-1:0] lk_dout;
    logic [W-1:0] lk_dout_mout;
    logic         lk_dout_valid;
    logic [W-1:0] cur_min;
    logic [W-1:0] cur_mout;
    logic         rnd_valid = 1'b0;
    logic [W-1:0] rnd_data = '0;
    logic         rnd_ready;
    logic         busy;
    logic         swap_pulse;
    logic         ready;
    logic         active_ctx;

    int errs = 0;
    int checks = 0;
    logic [7:0] alog [256];
    logic [7:0] lg   [256];

    always #4 clk = ~clk;

    msbox_table #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_dout(lk_dout), .lk_dout_mout(lk_dout_mout),
        .lk_dout_valid(lk_dout_valid), .cur_min(cur_min), .cur_mout(cur_mout),
        .rnd_valid(rnd_valid), .rnd_data(rnd_data), .rnd_ready(rnd_ready),
        .busy(busy), .swap_pulse(swap_pulse), .ready(ready),
        .active_ctx(active_ctx)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference S-box from generator-3 log/antilog tables.
    task automatic build_ref();
        logic [7:0] v;
        v = 8'h01;
        for (int i = 0; i < 255; i++) begin
            alog[i] = v;
            lg[v]   = 8'(i);
            v = v ^ ({v[6:0], 1'b0} ^ (v[7] ? 8'h1B : 8'h00));
        end
        alog[255] = 8'h01;
        lg[0] = 8'h00;
    endtask

    function automatic logic [7:0] ref_sbox(input logic [7:0] x);
        logic [7:0] b;
        int e;
        if (x == 8'h00) b = 8'h00;
        else begin
            e = (255 - int'(lg[x])) % 255;
            b = alog[e];
        end
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

    // Offer one random byte; returns at the falling edge after acceptance.
    task automatic give_rnd(input logic [7:0] b);
        rnd_valid = 1'b1;
        rnd_data  = b;
        while (!rnd_ready) @(negedge clk);
        @(negedge clk);
        rnd_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk(ready == 1'b0, "R1 ready", int'(ready), 0);
        chk(busy == 1'b1, "R1 busy", int'(busy), 1);
        chk(rnd_ready == 1'b1, "R1 rnd_ready", int'(rnd_ready), 1);
        chk(swap_pulse == 1'b0, "R1 swap_pulse", int'(swap_pulse), 0);
        chk(lk_dout_valid == 1'b0, "R1 lk_dout_valid", int'(lk_dout_valid), 0);
    endtask

    task automatic t_first_fill();
        int n;
        give_rnd(8'h5A);
        give_rnd(8'hC3);
        n = 1;
        while (!swap_pulse && n < 400) begin
            chk(ready == 1'b0, "R2 ready low during fill", int'(ready), 0);
            @(negedge clk);
            n++;
        end
        chk(n == 257, "R5 swap cycle", n, 257);
        @(negedge clk);
        chk(swap_pulse == 1'b0, "R5 single swap cycle", int'(swap_pulse), 0);
        chk(ready == 1'b1, "R2 ready after swap", int'(ready), 1);
        chk(active_ctx == 1'b0, "R2 context 0 active", int'(active_ctx), 0);
        chk(cur_min == 8'h5A, "R4 input mask", int'(cur_min), 'h5A);
        chk(cur_mout == 8'hC3, "R4 output mask", int'(cur_mout), 'hC3);
    endtask

    // Look up every byte of the active table; no randomness offered.
    task automatic t_sweep(input string tag);
        logic [7:0] m0;
        logic [7:0] mo;
        logic       c0;
        logic       sw_seen;
        m0 = cur_min;
        mo = cur_mout;
        c0 = active_ctx;
        sw_seen = 1'b0;
        for (int x = 0; x < 256; x++) begin
            lk_valid = 1'b1;
            lk_addr  = 8'(x) ^ cur_min;
            @(negedge clk);
            if (swap_pulse) sw_seen = 1'b1;
            chk(lk_dout_valid && lk_dout == (ref_sbox(8'(x)) ^ mo), {"R3 ", tag},
                int'(lk_dout), int'(ref_sbox(8'(x)) ^ mo));
            chk(lk_dout_mout == mo, "R3 reported mask", int'(lk_dout_mout), int'(mo));
        end
        lk_valid = 1'b0;
        chk(sw_seen == 1'b0, "R8 no swap without randomness", int'(sw_seen), 0);
        chk(busy && rnd_ready, "R8 waiting for randomness", int'({busy, rnd_ready}), 3);
        chk(cur_min == m0 && cur_mout == mo && active_ctx == c0, "R8 masks held",
            int'(cur_min), int'(m0));
    endtask

    // Refill under lookups every cycle, checking across the swap edge.
    task automatic t_live_refill(input logic [7:0] mi, input logic [7:0] mo);
        logic       c0;
        logic       sw;
        logic [7:0] exp_m;
        int         after;
        int         swaps;
        c0 = active_ctx;
        give_rnd(mi);
        give_rnd(mo);
        after = -1;
        swaps = 0;
        for (int k = 0; k < 300 && after < 4; k++) begin
            sw       = swap_pulse;
            lk_valid = 1'b1;
            lk_addr  = 8'(k * 7) ^ cur_min;
            exp_m    = cur_mout;
            @(negedge clk);
            chk(lk_dout_valid == 1'b1, "R6 no stall", int'(lk_dout_valid), 1);
            chk(lk_dout == (ref_sbox(8'(k * 7)) ^ exp_m) && lk_dout_mout == exp_m,
                sw ? "R7 swap-cycle lookup" : "R6 lookup during refill",
                int'(lk_dout), int'(ref_sbox(8'(k * 7)) ^ exp_m));
            if (sw) begin
                swaps++;
                chk(lk_dout_mout != mo || mo == exp_m, "R7 old mask used",
                    int'(lk_dout_mout), int'(exp_m));
                after = 0;
            end else if (after >= 0) after++;
        end
        lk_valid = 1'b0;
        chk(swaps == 1, "R9 one swap per refill", swaps, 1);
        chk(active_ctx == ~c0, "R9 context toggled", int'(active_ctx), int'(~c0));
        chk(cur_min == mi, "R4 new input mask", int'(cur_min), int'(mi));
        chk(cur_mout == mo, "R4 new output mask", int'(cur_mout), int'(mo));
    endtask

    // Zero masks leave the plain S-box visible; compare with known values.
    task automatic t_zero_masks();
        lk_valid = 1'b1;
        lk_addr  = 8'h00;
        @(negedge clk);
        chk(lk_dout == 8'h63, "R3 S(00) with zero masks", int'(lk_dout), 'h63);
        lk_addr = 8'h53;
        @(negedge clk);
        chk(lk_dout == 8'hED, "R3 S(53) with zero masks", int'(lk_dout), 'hED);
        lk_valid = 1'b0;
    endtask

    initial begin
        build_ref();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_fill();
        t_sweep("ctx0 sweep");
        t_live_refill(8'h11, 8'hEE);
        t_sweep("ctx1 sweep");
        t_live_refill(8'h00, 8'h00);
        t_zero_masks();
        t_sweep("zero-mask sweep");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule